// File: doc/BRIEF.md
# SPI Register Command Front End for a CAN-Style Controller

This block is an SPI slave that gives a host byte-level access to a 128-byte register space, laid out the way a small CAN controller lays out its registers. Every transaction is framed by the active-low chip select. The first byte is an opcode. Depending on the opcode, it is followed by an address, by a mask and data, or directly by buffer contents. The SPI pins are sampled with the fast system clock. A synchronizer and an edge detector turn them into byte events, and a command state machine interprets those events.

Apart from the two mode registers, the register space is plain storage. The control register at row offset 0xF holds a requested operating mode in bits [7:5]. The status register at row offset 0xE reports the mode that was accepted. Both appear at that offset in every 16-byte row. A one-byte reset command and the hardware reset return everything to a fixed configuration-mode state. A host can recognise that state by reading it back.

Command states:
- `S_OPCODE` waits for the opcode.
- `S_WR_ADDR`, `S_RD_ADDR` and `S_BM_ADDR` take the address byte.
- `S_BM_MASK` takes the mask.
- `S_BM_DATA` takes the modify data.
- `S_WR_STREAM` writes each byte and steps the pointer.
- `S_RD_STREAM` returns one register per byte and steps the pointer.
- `S_DISCARD` ignores everything until deselect.

Transitions:
- A completed opcode byte leaves `S_OPCODE` for the state that belongs to the command, or for `S_DISCARD` (reset or unknown opcode).
- Each address state moves on to its stream state or to `S_BM_MASK`.
- `S_BM_MASK` moves to `S_BM_DATA`, which moves to `S_DISCARD`.
- Chip select going high returns every state to `S_OPCODE`.

Top module: `spi_can_regs`

## Requirements
- R1: SPI mode 0 framing. The falling edge of chip select starts a command. Bits are taken MSB first on rising SCK, and MISO changes after falling SCK. A byte cut short by chip select rising is discarded and causes no write.
- R2: Opcode 0x02 takes an address byte and then any number of data bytes. Each data byte is written at the current address, which then increments modulo 128. Address bit 7 is ignored.
- R3: Opcode 0x03 takes an address byte. MISO is low during the opcode and address bytes. The third byte returns the register at that address, and each further byte returns the next address, modulo 128.
- R4: Opcode 0x05 takes an address, a mask and a data byte. Bits where the mask is 1 take the data value; bits where it is 0 keep their old value.
- R5: Opcodes 0x40, 0x42 and 0x44 (n = 0, 1, 2) write the following bytes from address 0x31 + 0x10·n upward. Opcode 0x46 is treated as unrecognised.
- R6: Opcode 0x90 returns registers from 0x61 upward and opcode 0x94 from 0x71 upward, starting in the byte after the opcode. MISO is low during the opcode byte. A 13-byte burst returns header and payload in order.
- R7: Opcode 0xC0 resets every register to its default and enters configuration mode. Later bytes of the same frame are ignored.
- R8: Defaults after reset: status reads 0x80 (so status AND 0xEE = 0x80), control reads 0x87 (so control AND 0x17 = 0x07), and every other byte reads 0x00.
- R9: Control bits [7:5] request a mode: 000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration. For these codes, status bits [7:5] take the requested code. Codes 101 to 111 leave status unchanged. Status bits [4:0] read 0, and writes to status are ignored.
- R10: In every 16-byte row, offset 0xE reads the one status register and offset 0xF accesses the one control register.
- R11: Any other opcode is ignored until chip select rises. MISO stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_csn | input | 1 | Active-low chip select that frames each command |
| spi_miso | output | 1 | Serial data to host; low while deselected |

## Verification
Some bytes cause two effects in the same system-clock cycle. A byte that completes a write or bit-modify to the control register also updates the status mode field in that cycle. In a streaming read, fetching the register for the next byte and advancing the pointer happen together. The bench provokes both situations:
- It writes the control register through plain writes, through a bit modify, and through a burst that crosses the status and control offsets and wraps past 0x7F.
- It requests legal and illegal mode codes.

It judges the outcome by reading status and control back, in separate frames and within one burst, and comparing them with values worked out from the mode rules.

// File: rtl/spi_regs_pkg.sv
`timescale 1ns/1ps
package spi_regs_pkg;

    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_BITMOD = 8'h05;
    localparam logic [7:0] OP_RDRX0  = 8'h90;
    localparam logic [7:0] OP_RDRX1  = 8'h94;
    localparam logic [7:0] OP_RESET  = 8'hC0;

    typedef enum logic [3:0] {
        S_OPCODE,
        S_WR_ADDR,
        S_RD_ADDR,
        S_BM_ADDR,
        S_BM_MASK,
        S_BM_DATA,
        S_WR_STREAM,
        S_RD_STREAM,
        S_DISCARD
    } cmd_state_t;

endpackage

// File: rtl/spi_bit_phy.sv
`timescale 1ns/1ps
// Oversampled SPI mode-0 slave: synchronizes pins, assembles bytes on
// rising SCK and shifts the reply out on falling SCK.
module spi_bit_phy #(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_csn,
    input  logic [WORD_W-1:0] tx_byte,
    output logic              byte_valid,
    output logic [WORD_W-1:0] rx_byte,
    output logic              cs_act,
    output logic              spi_miso
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [SYNC_STAGES-1:0] sck_sr, mosi_sr, csn_sr;
    logic                   sck_d;
    logic                   sck_s, mosi_s;
    logic                   sck_rise, sck_fall;
    logic [CNT_W-1:0]       bit_cnt;
    logic [WORD_W-2:0]      in_sh;
    logic [WORD_W-1:0]      out_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sr  <= '0;
            mosi_sr <= '0;
            csn_sr  <= '1;
            sck_d   <= 1'b0;
        end else begin
            sck_sr  <= {sck_sr[SYNC_STAGES-2:0], spi_sck};
            mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], spi_mosi};
            csn_sr  <= {csn_sr[SYNC_STAGES-2:0], spi_csn};
            sck_d   <= sck_s;
        end
    end

    assign sck_s    = sck_sr[SYNC_STAGES-1];
    assign mosi_s   = mosi_sr[SYNC_STAGES-1];
    assign cs_act   = ~csn_sr[SYNC_STAGES-1];
    assign sck_rise = cs_act & sck_s & ~sck_d;
    assign sck_fall = cs_act & ~sck_s & sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            in_sh      <= '0;
            out_sh     <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                out_sh  <= '0;
            end else begin
                if (sck_rise) begin
                    in_sh   <= {in_sh[WORD_W-3:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                        rx_byte    <= {in_sh, mosi_s};
                        byte_valid <= 1'b1;
                    end
                end
                if (sck_fall) begin
                    if (bit_cnt == '0) out_sh <= tx_byte;
                    else               out_sh <= {out_sh[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    assign spi_miso = cs_act & out_sh[WORD_W-1];

endmodule

// File: rtl/ctl_regfile.sv
`timescale 1ns/1ps
// Byte register space with one status and one control register aliased
// into every row; all other bytes are plain storage.
module ctl_regfile #(
    parameter int         ADDR_W   = 7,
    parameter int         ROW_SIZE = 16,
    parameter int         STAT_OFS = 14,
    parameter int         CTRL_OFS = 15,
    parameter logic [7:0] STAT_RST = 8'h80,
    parameter logic [7:0] CTRL_RST = 8'h87,
    parameter logic [2:0] MODE_MAX = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        wr_mask,
    output logic [7:0]        stat_o,
    output logic [7:0]        ctrl_o
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int ROW_BITS = $clog2(ROW_SIZE);

    logic [7:0] cells [DEPTH];
    logic [7:0] ctrl_q, ctrl_new;
    logic [2:0] mode_q;
    logic       ctrl_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        if ((i % ROW_SIZE) == STAT_OFS || (i % ROW_SIZE) == CTRL_OFS) begin : g_alias
            assign cells[i] = '0;
        end else begin : g_cell
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (soft_rst)
                    q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i))
                    q <= (q & ~wr_mask) | (wr_data & wr_mask);
            end
            assign cells[i] = q;
        end
    end

    assign ctrl_hit = wr_en && (wr_addr[ROW_BITS-1:0] == ROW_BITS'(CTRL_OFS));
    assign ctrl_new = (ctrl_q & ~wr_mask) | (wr_data & wr_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            mode_q <= STAT_RST[7:5];
        end else if (soft_rst) begin
            ctrl_q <= CTRL_RST;
            mode_q <= STAT_RST[7:5];
        end else if (ctrl_hit) begin
            ctrl_q <= ctrl_new;
            if (ctrl_new[7:5] <= MODE_MAX) mode_q <= ctrl_new[7:5];
        end
    end

    assign stat_o = {mode_q, STAT_RST[4:0]};
    assign ctrl_o = ctrl_q;

    always_comb begin
        if (rd_addr[ROW_BITS-1:0] == ROW_BITS'(STAT_OFS))
            rd_data = stat_o;
        else if (rd_addr[ROW_BITS-1:0] == ROW_BITS'(CTRL_OFS))
            rd_data = ctrl_q;
        else
            rd_data = cells[rd_addr];
    end

endmodule

// File: rtl/spi_cmd_fsm.sv
`timescale 1ns/1ps
// Opcode interpreter: one transition per received byte.
module spi_cmd_fsm
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int TX_BUFS    = 3,
    parameter int TX_BASE    = 'h31,
    parameter int RX_BASE    = 'h61,
    parameter int ROW_STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              cs_act,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [7:0]        wr_mask,
    output logic              soft_rst,
    output logic [7:0]        tx_byte,
    output cmd_state_t        state_o,
    output logic [ADDR_W-1:0] ptr_o
);
    cmd_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        mask_q;
    logic [7:0]        tx_q;
    logic              op_load, op_rxrd;
    logic [ADDR_W-1:0] load_base, rx_base;

    always_comb begin
        op_load   = (rx_byte[7:3] == 5'b01000) && !rx_byte[0] &&
                    (int'(rx_byte[2:1]) < TX_BUFS);
        op_rxrd   = (rx_byte == OP_RDRX0) || (rx_byte == OP_RDRX1);
        load_base = ADDR_W'(TX_BASE + ROW_STRIDE * int'(rx_byte[2:1]));
        rx_base   = ADDR_W'(RX_BASE + ROW_STRIDE * int'(rx_byte[2]));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OPCODE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = S_OPCODE;
        end else if (byte_valid) begin
            unique case (state_q)
                S_OPCODE: begin
                    if (rx_byte == OP_WRITE)       state_d = S_WR_ADDR;
                    else if (rx_byte == OP_READ)   state_d = S_RD_ADDR;
                    else if (rx_byte == OP_BITMOD) state_d = S_BM_ADDR;
                    else if (op_load)              state_d = S_WR_STREAM;
                    else if (op_rxrd)              state_d = S_RD_STREAM;
                    else                           state_d = S_DISCARD;
                end
                S_WR_ADDR:   state_d = S_WR_STREAM;
                S_RD_ADDR:   state_d = S_RD_STREAM;
                S_BM_ADDR:   state_d = S_BM_MASK;
                S_BM_MASK:   state_d = S_BM_DATA;
                S_BM_DATA:   state_d = S_DISCARD;
                S_WR_STREAM: state_d = S_WR_STREAM;
                S_RD_STREAM: state_d = S_RD_STREAM;
                S_DISCARD:   state_d = S_DISCARD;
            endcase
        end
    end

    // outputs toward the register file
    always_comb begin
        rd_addr  = ptr_q;
        wr_en    = 1'b0;
        wr_addr  = ptr_q;
        wr_data  = rx_byte;
        wr_mask  = '1;
        soft_rst = 1'b0;
        unique case (state_q)
            S_OPCODE: begin
                rd_addr  = rx_base;
                soft_rst = byte_valid && (rx_byte == OP_RESET);
            end
            S_RD_ADDR:   rd_addr = rx_byte[ADDR_W-1:0];
            S_WR_STREAM: wr_en = byte_valid;
            S_BM_DATA: begin
                wr_en   = byte_valid;
                wr_mask = mask_q;
            end
            default: ;
        endcase
    end

    // pointer, mask and reply byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mask_q <= '0;
            tx_q   <= '0;
        end else if (byte_valid) begin
            tx_q <= '0;
            unique case (state_q)
                S_OPCODE: begin
                    if (op_load) ptr_q <= load_base;
                    if (op_rxrd) begin
                        ptr_q <= rd_addr + 1'b1;
                        tx_q  <= rd_data;
                    end
                end
                S_WR_ADDR, S_BM_ADDR: ptr_q <= rx_byte[ADDR_W-1:0];
                S_RD_ADDR, S_RD_STREAM: begin
                    ptr_q <= rd_addr + 1'b1;
                    tx_q  <= rd_data;
                end
                S_BM_MASK:   mask_q <= rx_byte;
                S_WR_STREAM: ptr_q  <= ptr_q + 1'b1;
                default: ;
            endcase
        end else if (!cs_act) begin
            tx_q <= '0;
        end
    end

    assign tx_byte = tx_q;
    assign state_o = state_q;
    assign ptr_o   = ptr_q;

endmodule

// File: rtl/spi_can_regs.sv
`timescale 1ns/1ps
module spi_can_regs
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic spi_csn,
    output logic spi_miso
);
    logic              byte_valid, cs_act, soft_rst, wr_en;
    logic [7:0]        rx_byte, tx_byte, rd_data, wr_data, wr_mask;
    logic [7:0]        stat, ctrl;
    logic [ADDR_W-1:0] rd_addr, wr_addr, ptr;
    cmd_state_t        state;

    spi_bit_phy #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(8)) u_phy (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_csn    (spi_csn),
        .tx_byte    (tx_byte),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .cs_act     (cs_act),
        .spi_miso   (spi_miso)
    );

    spi_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .rx_byte    (rx_byte),
        .cs_act     (cs_act),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_mask    (wr_mask),
        .soft_rst   (soft_rst),
        .tx_byte    (tx_byte),
        .state_o    (state),
        .ptr_o      (ptr)
    );

    ctl_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .stat_o   (stat),
        .ctrl_o   (ctrl)
    );

endmodule

// File: rtl/spi_can_regs_chk.sv
`timescale 1ns/1ps
module spi_can_regs_chk
    import spi_regs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input cmd_state_t state,
    input logic [6:0] ptr,
    input logic       wr_en,
    input logic [6:0] wr_addr,
    input logic [7:0] wr_mask,
    input logic       soft_rst,
    input logic [7:0] stat,
    input logic [7:0] ctrl
);
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        stat[7:5] <= 3'd4);  // R9

    AST_SOFTRST_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (stat == 8'h80 && ctrl == 8'h87));  // R7

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[3:0] == 4'hF) |=> (((ctrl ^ $past(ctrl)) & ~$past(wr_mask)) == 8'h00));  // R4

    AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[3:0] == 4'hE) |=> $stable(stat));  // R9

    AST_WRITE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> byte_valid);  // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && (state == S_WR_STREAM || state == S_RD_STREAM)) |=> ptr == $past(ptr) + 1'b1);  // R2

    AST_DISCARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DISCARD) |-> !wr_en);  // R11

endmodule

bind spi_can_regs spi_can_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .state      (state),
    .ptr        (ptr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_mask    (wr_mask),
    .soft_rst   (soft_rst),
    .stat       (stat),
    .ctrl       (ctrl)
);

// File: tb/tb_spi_can_regs.sv
`timescale 1ns/1ps
module tb_spi_can_regs;

    localparam int HALF = 40;

    typedef struct packed {
        logic [7:0] waddr;
        logic [7:0] wdata;
        logic [7:0] raddr;
        logic [7:0] expv;
    } vec_t;

    // write one byte, then read one byte back in a new frame
    localparam vec_t VECS [8] = '{
        '{8'h10, 8'hA5, 8'h10, 8'hA5},  // plain storage
        '{8'h0F, 8'h40, 8'h0E, 8'h40},  // loopback request shows in status
        '{8'h22, 8'h3C, 8'h3E, 8'h40},  // status alias in another row
        '{8'h2F, 8'h27, 8'h0F, 8'h27},  // control alias, sleep request
        '{8'h0F, 8'hE0, 8'h0E, 8'h20},  // illegal mode code keeps status
        '{8'h0E, 8'hFF, 8'h5E, 8'h20},  // status write ignored
        '{8'h0F, 8'h00, 8'h0E, 8'h00},  // normal mode
        '{8'h85, 8'h99, 8'h05, 8'h99}   // address bit 7 ignored
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_mosi = 1'b0;
    logic spi_csn = 1'b1;
    logic spi_miso;

    logic [7:0] tb_tx [16];
    logic [7:0] tb_rx [16];
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_can_regs dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_csn  (spi_csn),
        .spi_miso (spi_miso)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, expv);
        end
    endtask

    task automatic spi_frame(input int nbytes, input int tail_bits);
        int total;
        total = nbytes * 8 + tail_bits;
        for (int i = 0; i < 16; i++) tb_rx[i] = 8'h00;
        spi_csn = 1'b0;
        #(HALF);
        for (int k = 0; k < total; k++) begin
            int bi = k / 8;
            int bb = 7 - (k % 8);
            spi_mosi = tb_tx[bi][bb];
            #(HALF);
            tb_rx[bi][bb] = spi_miso;
            spi_sck = 1'b1;
            #(HALF);
            spi_sck = 1'b0;
        end
        spi_mosi = 1'b0;
        #(HALF);
        spi_csn = 1'b1;
        #(4 * HALF);
    endtask

    task automatic wr1(input logic [7:0] a, input logic [7:0] d);
        tb_tx[0] = 8'h02; tb_tx[1] = a; tb_tx[2] = d;
        spi_frame(3, 0);
    endtask

    task automatic rd(input logic [7:0] a, input int n);
        tb_tx[0] = 8'h03; tb_tx[1] = a;
        for (int i = 2; i < 16; i++) tb_tx[i] = 8'h00;
        spi_frame(2 + n, 0);
    endtask

    task automatic bm(input logic [7:0] a, input logic [7:0] m, input logic [7:0] d);
        tb_tx[0] = 8'h05; tb_tx[1] = a; tb_tx[2] = m; tb_tx[3] = d;
        spi_frame(4, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state (R8), read framing (R3)
        rd(8'h0E, 1);
        check("R3 opcode byte MISO low", tb_rx[0], 8'h00);
        check("R3 address byte MISO low", tb_rx[1], 8'h00);
        check("R8 status default", tb_rx[2], 8'h80);
        check("R8 status AND 0xEE", tb_rx[2] & 8'hEE, 8'h80);
        rd(8'h0F, 1);
        check("R8 control default", tb_rx[2], 8'h87);
        check("R8 control AND 0x17", tb_rx[2] & 8'h17, 8'h07);
        check("spi_miso idle low R1", {7'd0, spi_miso}, 8'h00);

        // vector table: R2 R3 R9 R10
        for (int v = 0; v < 8; v++) begin
            wr1(VECS[v].waddr, VECS[v].wdata);
            rd(VECS[v].raddr, 1);
            check($sformatf("R2/R9/R10 vector %0d", v), tb_rx[2], VECS[v].expv);
        end

        // R4 bit modify on storage
        wr1(8'h20, 8'hF0);
        bm(8'h20, 8'h3C, 8'hAA);
        rd(8'h20, 1);
        check("R4 masked update", tb_rx[2], 8'hE8);

        // R2 burst across status/control and wrap past 0x7F
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h7D;
        tb_tx[2] = 8'h5A; tb_tx[3] = 8'hFF; tb_tx[4] = 8'h87; tb_tx[5] = 8'h66;
        spi_frame(6, 0);
        rd(8'h7D, 4);
        check("R2 burst byte 0x7D", tb_rx[2], 8'h5A);
        check("R10 status in last row", tb_rx[3], 8'h80);
        check("R10 control in last row", tb_rx[4], 8'h87);
        check("R2 wrap to 0x00", tb_rx[5], 8'h66);

        // R4 bit modify on control drives mode (R9)
        bm(8'h0F, 8'hE0, 8'h40);
        rd(8'h0E, 2);
        check("R9 status after masked mode", tb_rx[2], 8'h40);
        check("R4 control after masked mode", tb_rx[3], 8'h47);

        // R5 transmit buffer loads
        tb_tx[0] = 8'h42;
        for (int i = 1; i <= 6; i++) tb_tx[i] = 8'(i);
        spi_frame(7, 0);
        rd(8'h41, 6);
        for (int i = 0; i < 6; i++)
            check($sformatf("R5 buffer 1 byte %0d", i), tb_rx[2 + i], 8'(i + 1));
        tb_tx[0] = 8'h44; tb_tx[1] = 8'h77;
        spi_frame(2, 0);
        rd(8'h51, 1);
        check("R5 buffer 2 first byte", tb_rx[2], 8'h77);
        tb_tx[0] = 8'h46; tb_tx[1] = 8'h99;
        spi_frame(2, 0);
        rd(8'h61, 1);
        check("R5 opcode 0x46 not a load", tb_rx[2], 8'h00);

        // R6 receive buffer reads
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h61;
        for (int i = 0; i < 13; i++) tb_tx[2 + i] = 8'hB0 + 8'(i);
        spi_frame(15, 0);
        tb_tx[0] = 8'h90;
        for (int i = 1; i < 16; i++) tb_tx[i] = 8'h00;
        spi_frame(14, 0);
        check("R6 opcode byte MISO low", tb_rx[0], 8'h00);
        for (int i = 0; i < 13; i++)
            check($sformatf("R6 buffer 0 byte %0d", i), tb_rx[1 + i], 8'hB0 + 8'(i));
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h71; tb_tx[2] = 8'h5C; tb_tx[3] = 8'hC5;
        spi_frame(4, 0);
        tb_tx[0] = 8'h94; tb_tx[1] = 8'h00; tb_tx[2] = 8'h00;
        spi_frame(3, 0);
        check("R6 buffer 1 byte 0", tb_rx[1], 8'h5C);
        check("R6 buffer 1 byte 1", tb_rx[2], 8'hC5);

        // R11 unknown opcode
        tb_tx[0] = 8'h7A; tb_tx[1] = 8'h10; tb_tx[2] = 8'h00; tb_tx[3] = 8'h55;
        spi_frame(4, 0);
        check("R11 MISO low byte 1", tb_rx[1], 8'h00);
        check("R11 MISO low byte 2", tb_rx[2], 8'h00);
        check("R11 MISO low byte 3", tb_rx[3], 8'h00);
        rd(8'h10, 1);
        check("R11 no register change", tb_rx[2], 8'hA5);

        // R1 partial byte dropped
        tb_tx[0] = 8'h02; tb_tx[1] = 8'h10; tb_tx[2] = 8'h3C;
        spi_frame(2, 4);
        rd(8'h10, 1);
        check("R1 partial byte discarded", tb_rx[2], 8'hA5);

        // R7 soft reset, trailing byte ignored
        tb_tx[0] = 8'hC0; tb_tx[1] = 8'h02;
        spi_frame(2, 0);
        rd(8'h0E, 2);
        check("R7 status after reset", tb_rx[2], 8'h80);
        check("R7 control after reset", tb_rx[3], 8'h87);
        rd(8'h10, 1);
        check("R7 storage cleared", tb_rx[2], 8'h00);
        rd(8'h41, 1);
        check("R7 buffer cleared", tb_rx[2], 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule